// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a clock-enable strobe, pulsed once per period of a 32.768 kHz time base, into a programmable periodic tick. Software writes one 8-bit control byte that holds a 4-bit rate code and a 3-bit time-base code. While the settings are valid, the block emits a one-cycle pulse on each completed period. That pulse is meant to set a periodic-event flag further downstream. The block also drives a square wave that changes level on every tick.

Only one time-base code selects the 32.768 kHz base. Any other code leaves the tick idle, because this block does not build dividers for other bases. The rate codes do not run in order. Codes 1 and 2 repeat the periods of codes 8 and 9, and code 3 gives the shortest period. Every write to the control byte restarts the divider from zero. The new setting therefore takes effect from a known phase.

Top module: `ppi_divider`

## Requirements
- R1: With rate code 0 (control bits 3:0), `per_tick` never pulses.
- R2: The tick runs only when the time-base field (control bits 6:4) equals 2. For any other value, `per_tick` stays low and the square state stays low.
- R3: For rate codes 3 to 15, one tick is produced every 2^(code-1) asserted `tb_en` strobes (code 3: 4 strobes, code 15: 16384 strobes).
- R4: Rate code 1 gives one tick every 128 strobes, and rate code 2 gives one tick every 256 strobes.
- R5: `per_tick` is high for exactly one cycle. It rises one clock after the edge that samples the strobe completing the period.
- R6: The write strobe `cfg_wr` loads the control byte, clears the strobe count and clears the square state. A strobe that arrives in the same cycle as a write is not counted.
- R7: The square state inverts on every tick.
- R8: `sq_out` shows the square state while `sq_en` is high, and is forced low while `sq_en` is low. The square state keeps toggling underneath.
- R9: After reset the rate code is 0, `per_tick` is low and `sq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_en | input | 1 | One-cycle strobe per 32.768 kHz time-base period |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte: bits 3:0 rate code, bits 6:4 time-base code, bit 7 unused |
| sq_en | input | 1 | Square-wave output enable |
| per_tick | output | 1 | One-cycle periodic pulse |
| sq_out | output | 1 | Gated square wave |

## Verification
The divider is driven with a strobe on every clock and with a strobe on every third clock. This separates counting strobes from counting clocks. The short codes 3, 4 and 6, the aliased codes 1 and 2, and the longest code 15 are each run over several periods, which exposes any off-by-one in the shift mask and any wrong alias. Rate 0 and time-base codes other than 2 are held long enough to show that no tick appears. A rewrite in the middle of a period shows that the restart realigns the phase. Toggling `sq_en` while ticks continue separates output gating from the square state.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
   localparam int CTL_W      = 8;
   localparam int RATE_LSB   = 0;
   localparam int TBASE_LSB  = 4;

   // shift count of the divide-by-2^k for a rate code (aliases for 1 and 2)
   function automatic int unsigned rate_shift(input int unsigned code);
      if (code == 1)      return 7;
      else if (code == 2) return 8;
      else if (code == 0) return 0;
      else                return code - 1;
   endfunction
endpackage

// File: rtl/ppi_rate_decode.sv
module ppi_rate_decode #(
   parameter int RATE_W = 4,
   parameter int CNT_W  = 14,
   localparam int SH_W  = $clog2(CNT_W + 1)
) (
   input  logic [RATE_W-1:0] rate,
   output logic              rate_on,
   output logic [CNT_W-1:0]  term_cnt
);
   logic [SH_W-1:0] shift;

   always_comb begin
      shift    = SH_W'(ppi_pkg::rate_shift(int'(rate)));
      rate_on  = (rate != '0);
      term_cnt = ~({CNT_W{1'b1}} << shift);
   end
endmodule

// File: rtl/ppi_prescaler.sv
module ppi_prescaler #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic             step,
   input  logic [CNT_W-1:0] term_cnt,
   output logic             fire,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;

   assign fire = !restart && run && step && (cnt_q == term_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= fire;
         if (restart || fire)
            cnt_q <= '0;
         else if (run && step)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0 && !tick));
   a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= term_cnt);
endmodule

// File: rtl/ppi_square.sv
module ppi_square #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic toggle,
   input  logic gate,
   output logic state,
   output logic out
);
   always_ff @(posedge clk) begin
      if (!rst_n)      state <= 1'b0;
      else if (clear)  state <= 1'b0;
      else if (toggle) state <= ~state;
   end

   generate
      if (OUT_REG) begin : g_reg_out
         logic out_q;
         always_ff @(posedge clk) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= state & gate;
         end
         assign out = out_q;
      end else begin : g_comb_out
         assign out = state & gate;
      end
   endgenerate
endmodule

// File: rtl/ppi_divider.sv
module ppi_divider #(
   parameter int RATE_W     = 4,
   parameter int TBASE_W    = 3,
   parameter int TBASE_CODE = 2,
   parameter bit SQ_OUT_REG = 1'b0,
   localparam int CNT_W     = (1 << RATE_W) - 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tb_en,
   input  logic       cfg_wr,
   input  logic [7:0] cfg_wdata,
   input  logic       sq_en,
   output logic       per_tick,
   output logic       sq_out
);
   import ppi_pkg::*;

   generate
      if (RATE_W < 2 || RATE_W > 5) begin : g_bad_rate
         $error("ppi_divider: RATE_W out of range");
      end
      if (TBASE_LSB + TBASE_W > CTL_W || RATE_LSB + RATE_W > TBASE_LSB) begin : g_bad_field
         $error("ppi_divider: control fields overlap or overflow");
      end
      if (TBASE_CODE >= (1 << TBASE_W)) begin : g_bad_code
         $error("ppi_divider: TBASE_CODE does not fit");
      end
   endgenerate

   logic [RATE_W-1:0]  rate_q;
   logic [TBASE_W-1:0] tbase_q;
   logic               rate_on;
   logic [CNT_W-1:0]   term_cnt;
   logic               active;
   logic               fire;
   logic               sq_state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q  <= '0;
         tbase_q <= '0;
      end else if (cfg_wr) begin
         rate_q  <= cfg_wdata[RATE_LSB +: RATE_W];
         tbase_q <= cfg_wdata[TBASE_LSB +: TBASE_W];
      end
   end

   ppi_rate_decode #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_decode (
      .rate     (rate_q),
      .rate_on  (rate_on),
      .term_cnt (term_cnt)
   );

   assign active = rate_on && (tbase_q == TBASE_W'(TBASE_CODE));

   ppi_prescaler #(.CNT_W(CNT_W)) u_prescale (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (cfg_wr),
      .run      (active),
      .step     (tb_en),
      .term_cnt (term_cnt),
      .fire     (fire),
      .tick     (per_tick)
   );

   ppi_square #(.OUT_REG(SQ_OUT_REG)) u_square (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (cfg_wr),
      .toggle (fire),
      .gate   (sq_en),
      .state  (sq_state),
      .out    (sq_out)
   );

   a_r1_rate_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q == '0) |=> !per_tick);
   a_r2_tbase_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (tbase_q != TBASE_W'(TBASE_CODE)) |=> !per_tick);
   a_r7_square_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cfg_wr) && (sq_state != $past(sq_state))) |-> per_tick);
endmodule

// File: tb/ppi_divider_bench.sv
module ppi_divider_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tb_en = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       sq_en = 1'b0;
   logic       per_tick;
   logic       sq_out;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string req = "R9";

   // reference model state
   int m_rate = 0, m_tb = 0, m_cnt = 0;
   bit m_sq = 1'b0, m_tick = 1'b0;

   always #10 clk = ~clk;

   ppi_divider u_ppi_divider (
      .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .sq_en(sq_en), .per_tick(per_tick), .sq_out(sq_out)
   );

   function automatic int period(input int code);
      if (code == 1) return 128;
      if (code == 2) return 256;
      return 1 << (code - 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rate = 0; m_tb = 0; m_cnt = 0; m_sq = 0; m_tick = 0;
      end else begin
         m_tick = 0;
         if (cfg_wr) begin
            m_rate = cfg_wdata[3:0];
            m_tb   = cfg_wdata[6:4];
            m_cnt  = 0;
            m_sq   = 0;
         end else if (m_rate != 0 && m_tb == 2 && tb_en) begin
            m_cnt++;
            if (m_cnt == period(m_rate)) begin
               m_cnt  = 0;
               m_tick = 1;
               m_sq   = ~m_sq;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         bit exp_sq;
         exp_sq = m_sq & sq_en;
         n_vec++;
         if (per_tick !== m_tick) begin
            n_bad++;
            $display("FAIL %s per_tick actual=%0b expected=%0b t=%0t", req, per_tick, m_tick, $time);
         end
         if (sq_out !== exp_sq) begin
            n_bad++;
            $display("FAIL %s sq_out actual=%0b expected=%0b t=%0t", req, sq_out, exp_sq, $time);
         end
      end
   end

   task automatic write_ctl(input logic [7:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = v; tb_en = 1'b1;  // R6: strobe during write ignored
      @(negedge clk);
      cfg_wr = 1'b0; tb_en = 1'b0;
   endtask

   task automatic run(input int cycles, input int en_div);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         tb_en = ((k % en_div) == 0);
      end
   endtask

   initial begin
      req = "R9";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      sq_en = 1'b1;
      run(10, 1);                          // R9: idle after reset, rate 0
      req = "R3"; write_ctl(8'h23); run(60, 1);   // R3 R5 R7: divide by 4
      req = "R8"; sq_en = 1'b0; run(30, 1); sq_en = 1'b1; run(20, 1);
      req = "R3"; write_ctl(8'h24); run(240, 3);  // divide by 8, sparse strobes
      req = "R4"; write_ctl(8'h21); run(420, 1);  // code 1 -> 128
      req = "R4"; write_ctl(8'h22); run(800, 1);  // code 2 -> 256
      req = "R1"; write_ctl(8'h20); run(300, 1);  // rate 0
      req = "R2"; write_ctl(8'h33); run(300, 1);  // time base 3
      req = "R2"; write_ctl(8'h03); run(100, 1);  // time base 0
      req = "R6"; write_ctl(8'h26); run(20, 1);   // divide by 32, restart mid period
      write_ctl(8'h26); run(100, 1);
      req = "R5"; write_ctl(8'hA7); run(200, 1);  // bit 7 unused, divide by 64
      req = "R3"; write_ctl(8'h2F); run(33000, 1); // divide by 16384
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule